// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small fully associative translation buffer that turns a virtual address into a physical address. Each slot holds a virtual page number, a physical frame number, an address-space tag, a valid flag and a global flag. A lookup is purely combinational. It compares the page number of the incoming address, together with the current address-space ID, against every slot in parallel. On a hit it returns the frame number joined to the untouched page offset.

A write port installs a new translation. It uses the lowest free slot, or a round-robin victim once every slot is in use. A flush port runs on a context switch. It either clears the whole table or clears only the slots that are not marked global, so shared kernel translations stay warm. Because of the tag, translations from different address spaces for the same page number can share the table without any flush.

Top module: `asid_tlb`

## Requirements
- R1: The low OFFSET_W (default 12) bits of the lookup address are the page offset. All bits above them, VPN_W (default 36) bits, form the page number that is compared.
- R2: A non-global slot hits only when it is valid, its page number equals the lookup page number, and its tag equals `lookup_asid_i`.
- R3: A valid slot whose global flag is 1 hits on page number alone, whatever its tag.
- R4: On a hit, `lookup_pa_o` is `{frame, offset}`, with the offset bits copied unchanged. On a miss, `lookup_hit_o` is 0 and `lookup_pa_o` is all zeros.
- R5: A lookup result follows the lookup inputs within the same cycle, with no clock edge in between.
- R6: A write goes to the lowest-indexed invalid slot and can be seen by lookups after the next rising clock edge.
- R7: When every slot is valid, a write replaces the slot named by a round-robin pointer. The pointer is 0 after reset and advances by one, wrapping at the top, only on such writes.
- R8: A flush with `flush_all_i`=1 invalidates every slot on the next rising edge.
- R9: A flush with `flush_all_i`=0 invalidates every non-global slot and leaves global slots valid and unchanged.
- R10: If a flush and a write are requested in the same cycle, the flush takes effect and the write is dropped.
- R11: If several slots match a lookup, the lowest-indexed matching slot supplies the frame.
- R12: After reset every slot is invalid, so every lookup misses.
- R13: Slots with the same page number and different tags coexist. Each lookup returns only the slot owned by the current tag, or a global slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lookup_va_i | input | VPN_W+OFFSET_W | Virtual address to translate |
| lookup_asid_i | input | ASID_W | Current address-space ID |
| lookup_hit_o | output | 1 | Translation found |
| lookup_pa_o | output | PFN_W+OFFSET_W | Physical address, zero on miss |
| fill_en_i | input | 1 | Install a translation |
| fill_vpn_i | input | VPN_W | Page number to install |
| fill_pfn_i | input | PFN_W | Frame number to install |
| fill_asid_i | input | ASID_W | Owning address-space tag |
| fill_global_i | input | 1 | Mark the slot global |
| flush_en_i | input | 1 | Flush request |
| flush_all_i | input | 1 | 1: clear all slots, 0: keep global slots |

## Verification
Lookup results are combinational and due in the cycle the address is applied. The bench drives the address just after a falling edge and samples one time unit later, before any rising edge can intervene. Writes and flushes are due after exactly one rising edge. The bench raises each request after a falling edge and drops it at the next falling edge, so one rising edge commits it. It then looks up only after that, and compares against a reference table that it updates at the same point. Replacement order, global survival after a selective flush, and the flush-beats-write rule are all observed through lookups of every slot the reference table knows about.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned PAGE_OFFSET_W = 12;

  typedef enum logic {
    FLUSH_KEEP_GLOBAL = 1'b0,
    FLUSH_EVERYTHING  = 1'b1
  } flush_kind_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int unsigned N      = 16,
  parameter int unsigned VPN_W  = 36,
  parameter int unsigned ASID_W = 8,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]      valid_i,
  input  logic [N-1:0]      glob_i,
  input  logic [VPN_W-1:0]  vpn_i  [N],
  input  logic [ASID_W-1:0] asid_i [N],
  input  logic [VPN_W-1:0]  req_vpn_i,
  input  logic [ASID_W-1:0] req_asid_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [N-1:0] match_vec;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_vec[g] = valid_i[g] && (vpn_i[g] == req_vpn_i) &&
                          (glob_i[g] || (asid_i[g] == req_asid_i));
  end

  // descending scan: lowest match wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_vec[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |match_vec;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned N      = 16,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     valid_i,
  input  logic             alloc_i,
  output logic [IDX_W-1:0] victim_o,
  output logic             full_o
);
  logic [IDX_W-1:0] rr_q;

  assign full_o = &valid_i;

  always_comb begin
    victim_o = rr_q;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) victim_o = IDX_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (alloc_i && full_o) begin
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  a_r6_free_slot_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && !full_o) |-> !valid_i[victim_o]);

  a_r7_rr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && full_o) |=>
      (rr_q == (($past(rr_q) == IDX_W'(N - 1)) ? '0 : $past(rr_q) + 1'b1)));

  a_r7_rr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(alloc_i && full_o) |=> $stable(rr_q));
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int unsigned N        = 16,
  parameter int unsigned VPN_W    = 36,
  parameter int unsigned PFN_W    = 28,
  parameter int unsigned ASID_W   = 8,
  parameter int unsigned OFFSET_W = tlb_pkg::PAGE_OFFSET_W,
  localparam int unsigned VA_W    = VPN_W + OFFSET_W,
  localparam int unsigned PA_W    = PFN_W + OFFSET_W,
  localparam int unsigned IDX_W   = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VA_W-1:0]   lookup_va_i,
  input  logic [ASID_W-1:0] lookup_asid_i,
  output logic              lookup_hit_o,
  output logic [PA_W-1:0]   lookup_pa_o,
  input  logic              fill_en_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic              fill_global_i,
  input  logic              flush_en_i,
  input  logic              flush_all_i
);
  import tlb_pkg::*;

  logic [N-1:0]      valid_q, glob_q;
  logic [VPN_W-1:0]  vpn_q  [N];
  logic [PFN_W-1:0]  pfn_q  [N];
  logic [ASID_W-1:0] asid_q [N];

  logic [VPN_W-1:0]    req_vpn;
  logic [OFFSET_W-1:0] req_off;
  logic                hit;
  logic [IDX_W-1:0]    hit_idx, victim;
  logic                full, fill_we;
  flush_kind_e         flush_kind;

  assign req_vpn    = lookup_va_i[VA_W-1:OFFSET_W];
  assign req_off    = lookup_va_i[OFFSET_W-1:0];
  assign flush_kind = flush_kind_e'(flush_all_i);
  assign fill_we    = fill_en_i && !flush_en_i;  // flush wins

  tlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
    .valid_i    (valid_q),
    .glob_i     (glob_q),
    .vpn_i      (vpn_q),
    .asid_i     (asid_q),
    .req_vpn_i  (req_vpn),
    .req_asid_i (lookup_asid_i),
    .hit_o      (hit),
    .idx_o      (hit_idx)
  );

  tlb_victim #(.N(N)) u_victim (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_q),
    .alloc_i  (fill_we),
    .victim_o (victim),
    .full_o   (full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      glob_q  <= '0;
    end else if (flush_en_i) begin
      if (flush_kind == FLUSH_EVERYTHING) valid_q <= '0;
      else                                valid_q <= valid_q & glob_q;
    end else if (fill_en_i) begin
      valid_q[victim] <= 1'b1;
      glob_q[victim]  <= fill_global_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_we) begin
      vpn_q[victim]  <= fill_vpn_i;
      pfn_q[victim]  <= fill_pfn_i;
      asid_q[victim] <= fill_asid_i;
    end
  end

  assign lookup_hit_o = hit;
  assign lookup_pa_o  = hit ? {pfn_q[hit_idx], req_off} : '0;

  a_r4_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_hit_o |-> (lookup_pa_o == '0));

  a_r4_offset_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_hit_o |-> (lookup_pa_o[OFFSET_W-1:0] == lookup_va_i[OFFSET_W-1:0]));

  a_r2_hit_owned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_hit_o |-> (valid_q[hit_idx] && vpn_q[hit_idx] == req_vpn &&
                      (glob_q[hit_idx] || asid_q[hit_idx] == lookup_asid_i)));

  a_r8_flush_all_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_en_i && flush_all_i) |=> (valid_q == '0));

  a_r9_global_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_en_i && !flush_all_i) |=> (valid_q == $past(valid_q & glob_q)));

  a_r10_flush_no_growth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_en_i |=> ($countones(valid_q) <= $past($countones(valid_q))));
endmodule

// File: tb/tb_asid_tlb.sv
module tb_asid_tlb;
  localparam int N = 16, VPN_W = 36, PFN_W = 28, ASID_W = 8, OFF_W = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [VPN_W+OFF_W-1:0] va = '0;
  logic [ASID_W-1:0] asid = '0;
  logic hit;
  logic [PFN_W+OFF_W-1:0] pa;
  logic fill_en = 0, fill_g = 0, flush_en = 0, flush_all = 0;
  logic [VPN_W-1:0] f_vpn = '0;
  logic [PFN_W-1:0] f_pfn = '0;
  logic [ASID_W-1:0] f_asid = '0;

  always #2 clk = ~clk;  // 250 MHz

  asid_tlb dut (
    .clk_i(clk), .rst_ni(rst_n), .lookup_va_i(va), .lookup_asid_i(asid),
    .lookup_hit_o(hit), .lookup_pa_o(pa), .fill_en_i(fill_en),
    .fill_vpn_i(f_vpn), .fill_pfn_i(f_pfn), .fill_asid_i(f_asid),
    .fill_global_i(fill_g), .flush_en_i(flush_en), .flush_all_i(flush_all));

  int n_chk = 0, n_fail = 0;
  bit m_v [N];
  bit m_g [N];
  logic [VPN_W-1:0] m_vpn [N];
  logic [PFN_W-1:0] m_pfn [N];
  logic [ASID_W-1:0] m_asid [N];
  int m_rr = 0;

  task automatic model_fill(input logic [VPN_W-1:0] v, input logic [PFN_W-1:0] p,
                            input logic [ASID_W-1:0] a, input bit g);
    int slot = -1;
    for (int i = 0; i < N; i++) if (!m_v[i] && slot < 0) slot = i;
    if (slot < 0) begin slot = m_rr; m_rr = (m_rr + 1) % N; end
    m_v[slot] = 1; m_g[slot] = g; m_vpn[slot] = v; m_pfn[slot] = p; m_asid[slot] = a;
  endtask

  task automatic look(input logic [VPN_W-1:0] v, input logic [OFF_W-1:0] off,
                      input logic [ASID_W-1:0] a, input string req);
    bit e_hit = 0;
    logic [PFN_W+OFF_W-1:0] e_pa = '0;
    for (int i = N - 1; i >= 0; i--)
      if (m_v[i] && m_vpn[i] == v && (m_g[i] || m_asid[i] == a)) begin
        e_hit = 1; e_pa = {m_pfn[i], off};
      end
    va = {v, off}; asid = a;
    #1;  // same cycle, no edge (R5)
    n_chk++;
    if (hit !== e_hit || pa !== e_pa) begin
      n_fail++;
      $display("FAIL %s vpn=%h asid=%h hit=%b pa=%h expected hit=%b pa=%h",
               req, v, a, hit, pa, e_hit, e_pa);
    end
  endtask

  task automatic scan(input string req);
    for (int i = 0; i < N; i++) if (m_vpn[i] !== 'x) look(m_vpn[i], 12'h5a5, m_asid[i], req);
  endtask

  task automatic fill(input logic [VPN_W-1:0] v, input logic [PFN_W-1:0] p,
                      input logic [ASID_W-1:0] a, input bit g);
    @(negedge clk);
    fill_en = 1; f_vpn = v; f_pfn = p; f_asid = a; fill_g = g;
    @(negedge clk);
    fill_en = 0;
    model_fill(v, p, a, g);
  endtask

  task automatic flush(input bit all, input bit with_fill);
    @(negedge clk);
    flush_en = 1; flush_all = all;
    if (with_fill) begin fill_en = 1; f_vpn = 36'hBAD; f_pfn = 28'hBAD; f_asid = 8'h07; fill_g = 1; end
    @(negedge clk);
    flush_en = 0; fill_en = 0;
    for (int i = 0; i < N; i++) if (all || !m_g[i]) m_v[i] = 0;
  endtask

  task automatic t_reset;  // R12
    @(negedge clk);
    look(36'h0, 12'h0, 8'h0, "R12");
    look(36'h123, 12'hfff, 8'h3, "R12");
  endtask

  task automatic t_basic;  // R1 R4 R5 R6
    fill(36'h7F3A12345, 28'h00000C4, 8'h01, 0);
    fill(36'h2B00F, 28'hABCDEF1, 8'h01, 0);
    @(negedge clk);
    look(36'h7F3A12345, 12'hABC, 8'h01, "R1");
    look(36'h2B00F, 12'h2A7, 8'h01, "R4");
    look(36'h2B00F, 12'h000, 8'h01, "R4");
    look(36'h2B010, 12'h2A7, 8'h01, "R4");
    look(36'h7F3A12345, 12'hfff, 8'h01, "R5");
    fill(36'h55, 28'h55, 8'h01, 0);
    @(negedge clk);
    look(36'h55, 12'h1, 8'h01, "R6");
  endtask

  task automatic t_asid;  // R2 R13
    fill(36'h400, 28'hA00, 8'h0A, 0);
    fill(36'h400, 28'hB00, 8'h0B, 0);
    @(negedge clk);
    look(36'h400, 12'h010, 8'h0A, "R13");
    look(36'h400, 12'h010, 8'h0B, "R13");
    look(36'h400, 12'h010, 8'h0C, "R2");
    look(36'h2B00F, 12'h2A7, 8'h02, "R2");
  endtask

  task automatic t_global;  // R3 R11
    fill(36'hFFFF0, 28'h0001, 8'h00, 1);
    @(negedge clk);
    look(36'hFFFF0, 12'h321, 8'h00, "R3");
    look(36'hFFFF0, 12'h321, 8'hEE, "R3");
    fill(36'h400, 28'hC00, 8'h33, 1);  // global duplicate above owned ones
    @(negedge clk);
    look(36'h400, 12'h0, 8'h0A, "R11");
    look(36'h400, 12'h0, 8'h77, "R11");
  endtask

  task automatic t_flush_all;  // R8
    flush(1, 0);
    scan("R8");
    look(36'hFFFF0, 12'h0, 8'h00, "R8");
  endtask

  task automatic t_round_robin;  // R7
    for (int i = 0; i < N; i++) fill(36'h1000 + 36'(i), 28'h200 + 28'(i), 8'h04, i[0]);
    scan("R7");
    fill(36'h9000, 28'h9000, 8'h04, 0);  // replaces slot 0
    fill(36'h9001, 28'h9001, 8'h05, 0);  // replaces slot 1
    @(negedge clk);
    look(36'h1000, 12'h0, 8'h04, "R7");
    look(36'h1001, 12'h0, 8'h04, "R7");
    look(36'h1002, 12'h0, 8'h04, "R7");
    scan("R7");
  endtask

  task automatic t_flush_keep;  // R9
    flush(0, 0);
    scan("R9");
    look(36'h1003, 12'h0, 8'h99, "R9");
    look(36'h1002, 12'h0, 8'h04, "R9");
  endtask

  task automatic t_flush_fill;  // R10
    flush(0, 1);
    look(36'hBAD, 12'h0, 8'h07, "R10");
    scan("R10");
    fill(36'hBAD, 28'hBAD, 8'h07, 0);
    @(negedge clk);
    look(36'hBAD, 12'h0, 8'h07, "R10");
  endtask

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_g[i] = 0; m_vpn[i] = 'x; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_asid();
    t_global();
    t_flush_all();
    t_round_robin();
    t_flush_keep();
    t_flush_fill();
    finish_run();
  end
endmodule